// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller decides when a single-slot coin acceptor has collected enough money to release one item. The slot takes two coin types, a five-cent piece and a ten-cent piece. Each coin is reported by a pulse that lasts one clock on its own input. The controller keeps a running credit of 0, 5, 10 or 15 cents. It raises its release output as soon as the credit reaches 15. Any overpayment is absorbed: a dime added to 10 cents still lands on 15. No change is returned.

The credit lives in a state register. A build parameter chooses how that register is encoded. The compact variant stores two bits, in the order 0, 5, 10, 15 = 00, 01, 10, 11. Its release signal is the AND of both bits. The one-hot variant stores four bits, one per credit value in the same order. Its release signal is the bit for 15 cents. The two variants behave identically at the pins. Once the controller reaches 15 cents, it stays there with the release output asserted until the host pulses the synchronous reset.

The named states are `CR_0`, `CR_5`, `CR_10` and `CR_15`. A decoded coin is one of `COIN_NONE`, `COIN_NICKEL` and `COIN_DIME`. The transitions are:

- CR_0 to CR_5 on a nickel, and CR_0 to CR_10 on a dime.
- CR_5 to CR_10 on a nickel, and CR_5 to CR_15 on a dime.
- CR_10 to CR_15 on either coin.
- Every state stays where it is when no coin arrives.
- CR_15 stays where it is for any coin.
- Every state goes to CR_0 on reset.

Top module: `vend_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the credit becomes 0 cents and `release_out` is low after that edge, whatever the previous state was.
- R2: A clock edge with both coin inputs low leaves the credit, and therefore `release_out`, unchanged.
- R3: From 0 cents, a nickel moves the credit to 5 cents and a dime moves it to 10 cents.
- R4: From 5 cents, a nickel moves the credit to 10 cents and a dime moves it to 15 cents.
- R5: From 10 cents, either coin moves the credit to 15 cents.
- R6: `release_out` is high exactly while the credit is 15 cents. It rises in the cycle after the edge that sampled the completing coin.
- R7: At 15 cents, further coins are ignored: `release_out` stays high until a reset.
- R8: A nickel and a dime asserted in the same cycle count as a single dime.
- R9: The binary build (`ONE_HOT`=0, state 00/01/10/11 for 0/5/10/15 cents) and the one-hot build (`ONE_HOT`=1, one bit per credit value in the same order) produce the same `release_out` on every cycle for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to 0 cents |
| nickel_in | input | 1 | One-cycle pulse per five-cent coin |
| dime_in | input | 1 | One-cycle pulse per ten-cent coin |
| release_out | output | 1 | High while the credit is 15 cents; drives the release mechanism |

## Verification
The hardest situation to produce is the illegal case of both coin pulses in one cycle. Its outcome shows only indirectly, because 10 cents and 5 cents both leave the release low. The stimulus therefore applies the double pulse from 0 cents and follows it with a single nickel. Only the dime reading of the double pulse opens the release on that nickel. A second hard case is the saturated state. There, coins are driven on purpose after release to show that nothing leaves 15 cents before the reset. The reset is then checked by a following nickel that must not open. Both encodings are run side by side from the same driver, so every compare covers R9.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Credit held by the controller, in ascending order of value.
    typedef enum logic [1:0] {
        CR_0  = 2'd0,
        CR_5  = 2'd1,
        CR_10 = 2'd2,
        CR_15 = 2'd3
    } credit_t;

    // Coin seen in one clock cycle after decoding the two pulse inputs.
    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2
    } coin_t;

    localparam int unsigned NUM_CREDITS = 4;
    localparam int unsigned BIN_BITS    = $clog2(NUM_CREDITS);

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_t coin_o
);

    // A dime pulse takes priority, so a double pulse reads as one dime (R8).
    always_comb begin
        if (dime_i) begin
            coin_o = COIN_DIME;
        end else if (nickel_i) begin
            coin_o = COIN_NICKEL;
        end else begin
            coin_o = COIN_NONE;
        end
    end

endmodule

// File: rtl/vend_next_credit.sv
module vend_next_credit
    import vend_pkg::*;
(
    input  credit_t credit_i,
    input  coin_t   coin_i,
    output credit_t credit_nxt_o
);

    always_comb begin
        credit_nxt_o = credit_i;
        unique case (credit_i)
            CR_0: begin
                if (coin_i == COIN_DIME) begin
                    credit_nxt_o = CR_10;
                end else if (coin_i == COIN_NICKEL) begin
                    credit_nxt_o = CR_5;
                end
            end
            CR_5: begin
                if (coin_i == COIN_DIME) begin
                    credit_nxt_o = CR_15;
                end else if (coin_i == COIN_NICKEL) begin
                    credit_nxt_o = CR_10;
                end
            end
            CR_10: begin
                if (coin_i != COIN_NONE) begin
                    credit_nxt_o = CR_15;
                end
            end
            CR_15: begin
                // Saturated: coins are absorbed, only reset leaves.
                credit_nxt_o = CR_15;
            end
            default: credit_nxt_o = CR_0;
        endcase
    end

endmodule

// File: rtl/vend_state_store.sv
module vend_state_store
    import vend_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
)(
    input  logic    clk,
    input  logic    rst,
    input  credit_t credit_nxt_i,
    output credit_t credit_o,
    output logic    release_o
);

    generate
        if (ONE_HOT) begin : g_onehot
            localparam int unsigned W = NUM_CREDITS;
            logic [W-1:0] q_r;
            logic [W-1:0] q_nxt;

            always_comb begin
                q_nxt = '0;
                q_nxt[credit_nxt_i] = 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r <= W'(1);
                end else begin
                    q_r <= q_nxt;
                end
            end

            always_comb begin
                if (q_r[3]) begin
                    credit_o = CR_15;
                end else if (q_r[2]) begin
                    credit_o = CR_10;
                end else if (q_r[1]) begin
                    credit_o = CR_5;
                end else begin
                    credit_o = CR_0;
                end
                release_o = q_r[3];
            end

            a_r9_onehot_valid: assert property (@(posedge clk) disable iff (rst)
                $countones(q_r) == 1);
        end else begin : g_binary
            logic [BIN_BITS-1:0] q_r;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r <= '0;
                end else begin
                    q_r <= credit_nxt_i;
                end
            end

            always_comb begin
                credit_o  = credit_t'(q_r);
                release_o = q_r[1] & q_r[0];
            end
        end
    endgenerate

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
)(
    input  logic clk,
    input  logic rst,
    input  logic nickel_in,
    input  logic dime_in,
    output logic release_out
);

    coin_t   coin;
    credit_t credit;
    credit_t credit_nxt;

    vend_coin_decode u_decode (
        .nickel_i (nickel_in),
        .dime_i   (dime_in),
        .coin_o   (coin)
    );

    vend_next_credit u_next (
        .credit_i     (credit),
        .coin_i       (coin),
        .credit_nxt_o (credit_nxt)
    );

    vend_state_store #(.ONE_HOT(ONE_HOT)) u_store (
        .clk          (clk),
        .rst          (rst),
        .credit_nxt_i (credit_nxt),
        .credit_o     (credit),
        .release_o    (release_out)
    );

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (credit == CR_0 && !release_out));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (coin == COIN_NONE) |=> $stable(credit));

    a_r3_nickel_from_zero: assert property (@(posedge clk) disable iff (rst)
        (credit == CR_0 && coin == COIN_NICKEL) |=> credit == CR_5);

    a_r5_ten_completes: assert property (@(posedge clk) disable iff (rst)
        (credit == CR_10 && coin != COIN_NONE) |=> release_out);

    a_r6_rise_after_coin: assert property (@(posedge clk) disable iff (rst)
        $rose(release_out) |-> $past(nickel_in || dime_in));

    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        release_out |=> release_out);

    a_r8_double_is_dime: assert property (@(posedge clk) disable iff (rst)
        (credit == CR_0 && nickel_in && dime_in) |=> credit == CR_10);

endmodule

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic rel_bin;
    logic rel_oh;

    int n_cmp = 0;
    int n_bad = 0;
    int cents = 0;
    bit done = 1'b0;
    item_t sb[$];

    always #5 clk = ~clk;

    vend_ctrl #(.ONE_HOT(1'b0)) dut (
        .clk(clk), .rst(rst), .nickel_in(nickel), .dime_in(dime),
        .release_out(rel_bin)
    );

    vend_ctrl #(.ONE_HOT(1'b1)) dut_oh (
        .clk(clk), .rst(rst), .nickel_in(nickel), .dime_in(dime),
        .release_out(rel_oh)
    );

    // Driver: applies one cycle of stimulus and queues the expected release.
    task automatic step(input logic n, input logic d, input logic r, input string tag);
        item_t it;
        @(negedge clk);
        nickel = n;
        dime   = d;
        rst    = r;
        if (r) begin
            cents = 0;
        end else if (cents != 15) begin
            if (d)      cents = cents + 10;
            else if (n) cents = cents + 5;
            if (cents > 15) cents = 15;
        end
        it.exp = (cents == 15);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: compares both builds just after the edge that consumed the item.
    always @(posedge clk) begin
        item_t got;
        #1;
        if (sb.size() > 0) begin
            got = sb.pop_front();
            n_cmp++;
            if (rel_bin !== got.exp) begin
                n_bad++;
                $display("FAIL %s binary release actual=%b expected=%b", got.tag, rel_bin, got.exp);
            end
            if (rel_oh !== got.exp) begin
                n_bad++;
                $display("FAIL %s R9 one-hot release actual=%b expected=%b", got.tag, rel_oh, got.exp);
            end
        end
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        // R1: reset state
        step(0, 0, 1, "R1");
        step(0, 0, 1, "R1");
        // R2: idle at zero
        step(0, 0, 0, "R2");
        step(0, 0, 0, "R2");
        // R3/R4/R5: three nickels with gaps
        step(1, 0, 0, "R3");
        step(0, 0, 0, "R2");
        step(1, 0, 0, "R4");
        step(0, 0, 0, "R2");
        step(1, 0, 0, "R5");
        // R7: coins after full are ignored
        step(1, 0, 0, "R7");
        step(0, 1, 0, "R7");
        step(1, 1, 0, "R7");
        step(0, 0, 0, "R7");
        // R1: reset from full
        step(0, 0, 1, "R1");
        step(0, 0, 0, "R1");
        // R3/R5: dime then nickel
        step(0, 1, 0, "R3");
        step(1, 0, 0, "R5");
        step(0, 0, 1, "R1");
        // R4: nickel then dime
        step(1, 0, 0, "R3");
        step(0, 1, 0, "R4");
        step(0, 0, 1, "R1");
        // R5: two dimes overpay and saturate
        step(0, 1, 0, "R3");
        step(0, 0, 0, "R2");
        step(0, 1, 0, "R5");
        step(0, 0, 0, "R6");
        step(0, 0, 1, "R1");
        // R8: double pulse from zero counts as a dime, then a nickel opens
        step(1, 1, 0, "R8");
        step(0, 0, 0, "R2");
        step(1, 0, 0, "R8");
        step(0, 0, 1, "R1");
        // R8: double pulse from five completes
        step(1, 0, 0, "R3");
        step(1, 1, 0, "R8");
        step(0, 0, 1, "R1");
        // R1: reset at ten discards credit; next nickel must not open
        step(0, 1, 0, "R3");
        step(0, 0, 1, "R1");
        step(1, 0, 0, "R1");
        step(0, 0, 0, "R6");
        step(1, 0, 0, "R6");
        step(0, 0, 0, "R6");
        step(0, 0, 0, "R6");
        repeat (3) @(posedge clk);
        #2;
        summary();
    end

endmodule